// File: doc/BRIEF.md
# Reset Sequencer with Shared Open-Drain Reset Pin

The block merges two reset causes into a single core reset and a gate on instruction fetch. One cause is a watchdog timeout request raised inside the chip. The other is a shared, active-low board reset line.

When the watchdog fires, the block turns on an open-drain pull-down on the shared line. This resets the other chips on the board as well. The pull-down stays on for a guaranteed number of reference clock cycles. After the block lets go of the line, it waits until the line actually reads high. It then counts a fixed delay before it opens instruction fetch. A board device that keeps the line low therefore holds the core in reset for as long as it does so.

The line is read through a synchronizer, so it may change at any time. Power-up is handled as an internal reset: the whole sequence runs once after `rst_ni` is released.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst_ni` is low, `pin_pd_o` is 1, `core_rst_o` is 1 and `fetch_en_o` is 0.
- R2: After `rst_ni` is released, `pin_pd_o` stays 1 for exactly `LOW_CYCLES` rising edges, counted from the first edge, and then drops to 0.
- R3: A watchdog request sampled high on an edge sets `pin_pd_o` to 1 and `fetch_en_o` to 0 from that edge on, whatever the state.
- R4: A watchdog request sampled while the pull-down is on restarts the interval. `pin_pd_o` drops exactly `LOW_CYCLES` edges after the last request edge.
- R5: When nothing else holds the line low, `fetch_en_o` rises exactly `FETCH_DELAY` edges after the edge on which `pin_pd_o` dropped. `FETCH_DELAY` must be at least `SYNC_STAGES`+2.
- R6: `pin_i` passes through a `SYNC_STAGES`-flop synchronizer. A low level from outside while running drops `fetch_en_o` exactly `SYNC_STAGES`+1 edges after it appears, and it never turns on `pin_pd_o`.
- R7: If the line stays low after the pull-down is released, or goes low again before fetch opens, `fetch_en_o` rises exactly `FETCH_DELAY` edges after the line returns high.
- R8: `core_rst_o` is always the inverse of `fetch_en_o`. Fetch is enabled only in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| wdt_req_i | input | 1 | Watchdog timeout request, synchronous to clk_i |
| pin_i | input | 1 | Level read back from the shared reset line (asynchronous) |
| pin_pd_o | output | 1 | Open-drain pull-down enable for the shared line (1 = pull low) |
| core_rst_o | output | 1 | Core reset, active high |
| fetch_en_o | output | 1 | Instruction fetch permitted |

## Verification
The assertions take three things for granted. The watchdog request is synchronous to the reference clock. The pad reads low whenever the pull-down is on. The delay parameter leaves room for the synchronizer latency. No assumption is made about when an external device pulls the line low. The bench models the line as a wired-AND of the pull-down and an external driver, and changes both inputs only on falling clock edges. External low pulses last longer than the synchronizer depth, so every level the design should react to is actually seen.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE_LOW,
    ST_WAIT_HIGH,
    ST_FETCH_DELAY,
    ST_RUN
  } rstseq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int unsigned LOW_CYCLES  = 1024,
  parameter int unsigned FETCH_DELAY = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_req_i,
  input  logic pin_hi_i,
  output logic pin_pd_o,
  output logic fetch_en_o,
  output logic core_rst_o
);
  localparam int unsigned MAXC = (LOW_CYCLES > FETCH_DELAY) ? LOW_CYCLES : FETCH_DELAY;
  localparam int unsigned CW   = $clog2(MAXC + 1) + 1;
  // synchronizer latency plus the WAIT_HIGH exit edge are already spent
  localparam logic [CW-1:0] LOW_LAST = CW'(LOW_CYCLES - 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(FETCH_DELAY - SYNC_STAGES - 2);

  rstseq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CW'(1);
    unique case (state_q)
      ST_IDLE: begin
        state_d = ST_DRIVE_LOW;
        cnt_d   = '0;
      end
      ST_DRIVE_LOW: begin
        if (cnt_q == LOW_LAST) begin
          state_d = ST_WAIT_HIGH;
          cnt_d   = '0;
        end
      end
      ST_WAIT_HIGH: begin
        cnt_d = '0;
        if (pin_hi_i) state_d = ST_FETCH_DELAY;
      end
      ST_FETCH_DELAY: begin
        if (!pin_hi_i) begin
          state_d = ST_WAIT_HIGH;
          cnt_d   = '0;
        end else if (cnt_q == DLY_LAST) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        cnt_d = '0;
        if (!pin_hi_i) state_d = ST_WAIT_HIGH;
      end
      default: begin
        state_d = ST_DRIVE_LOW;
        cnt_d   = '0;
      end
    endcase
    if (wdt_req_i) begin
      state_d = ST_DRIVE_LOW;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end

  assign pin_pd_o   = (state_q == ST_IDLE) || (state_q == ST_DRIVE_LOW);
  assign fetch_en_o = (state_q == ST_RUN);
  assign core_rst_o = !fetch_en_o;

  // assertion support: length of current pull-down, cycles since its release
  logic [CW-1:0] pd_len_q, since_rel_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pd_len_q    <= CW'(1);
      since_rel_q <= '0;
    end else begin
      if (!pin_pd_o)                   pd_len_q <= '0;
      else if (pd_len_q < CW'(MAXC))   pd_len_q <= pd_len_q + CW'(1);
      if (pin_pd_o)                    since_rel_q <= '0;
      else if (since_rel_q < CW'(MAXC)) since_rel_q <= since_rel_q + CW'(1);
    end

  p_wdt_pulls_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_req_i |=> (pin_pd_o && !fetch_en_o));

  p_min_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_pd_o) |-> (pd_len_q >= CW'(LOW_CYCLES)));

  p_fetch_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_en_o) |-> (since_rel_q >= CW'(FETCH_DELAY - 1)));

  p_pin_low_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_en_o && !pin_hi_i && !wdt_req_i) |=> (!fetch_en_o && !pin_pd_o));

  p_fetch_needs_pin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_en_o) |-> $past(pin_hi_i));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int unsigned LOW_CYCLES  = 1024,
  parameter int unsigned FETCH_DELAY = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_req_i,
  input  logic pin_i,
  output logic pin_pd_o,
  output logic core_rst_o,
  output logic fetch_en_o
);
  logic pin_hi;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_hi)
  );

  rstseq_fsm #(
    .LOW_CYCLES (LOW_CYCLES),
    .FETCH_DELAY(FETCH_DELAY),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdt_req_i (wdt_req_i),
    .pin_hi_i  (pin_hi),
    .pin_pd_o  (pin_pd_o),
    .fetch_en_o(fetch_en_o),
    .core_rst_o(core_rst_o)
  );

  p_core_rst_inv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o != fetch_en_o);
endmodule

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
  localparam int L = 1024;
  localparam int D = 16;
  localparam int S = 2;

  typedef enum int {EV_PD_RISE, EV_PD_FALL, EV_FETCH_FALL, EV_FETCH_RISE} ev_e;
  typedef struct {
    ev_e   kind;
    int    cyc;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_req = 1'b0;
  logic ext_low = 1'b0;
  logic pin_pd, core_rst, fetch_en;
  wire  pin_w = (pin_pd || ext_low) ? 1'b0 : 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  reset_sequencer #(.LOW_CYCLES(L), .FETCH_DELAY(D), .SYNC_STAGES(S)) u_reset_sequencer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wdt_req_i (wdt_req),
    .pin_i     (pin_w),
    .pin_pd_o  (pin_pd),
    .core_rst_o(core_rst),
    .fetch_en_o(fetch_en)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input ev_e k, input int c, input string req);
    exp_t e;
    e.kind = k; e.cyc = c; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(input ev_e k);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R6", "unexpected event kind", int'(k), -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k, e.req, "event kind", int'(k), int'(e.kind));
      check(e.cyc == cyc, e.req, "event cycle", cyc, e.cyc);
    end
  endtask

  // monitor
  logic pd_prev = 1'b1, fe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pin_pd !== pd_prev) observe(pin_pd ? EV_PD_RISE : EV_PD_FALL);
      if (fetch_en !== fe_prev) observe(fetch_en ? EV_FETCH_RISE : EV_FETCH_FALL);
    end
    pd_prev = pin_pd;
    fe_prev = fetch_en;
  end

  task automatic finish_run();
    if (exp_q.size() != 0) check(1'b0, "R5", "pending expected events", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic wdt_pulse(input string req);
    wdt_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int c, f, r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pin_pd === 1'b1, "R1", "pin_pd in reset", int'(pin_pd), 1);
    check(core_rst === 1'b1, "R1", "core_rst in reset", int'(core_rst), 1);
    check(fetch_en === 1'b0, "R1", "fetch_en in reset", int'(fetch_en), 0);

    // R2/R5 power-up sequence
    push(EV_PD_FALL, 1 + L, "R2");
    push(EV_FETCH_RISE, 1 + L + D, "R5");
    rst_n = 1'b1;
    drain();
    check(core_rst === 1'b0, "R8", "core_rst while running", int'(core_rst), 0);

    // R3 watchdog while running
    c = cyc;
    push(EV_PD_RISE, c + 1, "R3");
    push(EV_FETCH_FALL, c + 1, "R3");
    push(EV_PD_FALL, c + 1 + L, "R3");
    push(EV_FETCH_RISE, c + 1 + L + D, "R5");
    wdt_pulse("R3");
    check(core_rst === 1'b1, "R8", "core_rst after watchdog", int'(core_rst), 1);
    repeat (300) @(negedge clk);
    // R4 restart during pull-down
    c = cyc;
    void'(exp_q.pop_front()); void'(exp_q.pop_front());
    push(EV_PD_FALL, c + 1 + L, "R4");
    push(EV_FETCH_RISE, c + 1 + L + D, "R4");
    wdt_pulse("R4");
    drain();

    // R6 external reset while running
    c = cyc;
    push(EV_FETCH_FALL, c + S + 1, "R6");
    ext_low = 1'b1;
    repeat (40) @(negedge clk);
    check(pin_pd === 1'b0, "R6", "no pull-down on external reset", int'(pin_pd), 0);
    check(core_rst === 1'b1, "R8", "core_rst during external reset", int'(core_rst), 1);
    r = cyc;
    push(EV_FETCH_RISE, r + D, "R6");
    ext_low = 1'b0;
    drain();

    // R7 external hold past own release
    c = cyc;
    push(EV_PD_RISE, c + 1, "R3");
    push(EV_FETCH_FALL, c + 1, "R3");
    push(EV_PD_FALL, c + 1 + L, "R2");
    wdt_pulse("R3");
    ext_low = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (25) @(negedge clk);
    check(fetch_en === 1'b0, "R7", "fetch held by external low", int'(fetch_en), 0);
    r = cyc;
    push(EV_FETCH_RISE, r + D, "R7");
    ext_low = 1'b0;
    drain();

    // R7 external glitch during fetch delay
    c = cyc;
    push(EV_PD_RISE, c + 1, "R3");
    push(EV_FETCH_FALL, c + 1, "R3");
    push(EV_PD_FALL, c + 1 + L, "R2");
    wdt_pulse("R3");
    while (exp_q.size() != 0) @(negedge clk);
    f = cyc;
    repeat (S + 4) @(negedge clk);
    ext_low = 1'b1;
    repeat (4) @(negedge clk);
    r = cyc;
    ext_low = 1'b0;
    push(EV_FETCH_RISE, r + D, "R7");
    drain();
    check(f > 0, "R7", "glitch scenario reached", f, 1);

    // R4 watchdog during fetch delay
    c = cyc;
    push(EV_PD_RISE, c + 1, "R3");
    push(EV_FETCH_FALL, c + 1, "R3");
    push(EV_PD_FALL, c + 1 + L, "R2");
    wdt_pulse("R3");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (S + 5) @(negedge clk);
    c = cyc;
    push(EV_PD_RISE, c + 1, "R4");
    push(EV_PD_FALL, c + 1 + L, "R4");
    push(EV_FETCH_RISE, c + 1 + L + D, "R5");
    wdt_pulse("R4");
    drain();
    check(fetch_en === 1'b1, "R8", "fetch open at end", int'(fetch_en), 1);
    check(core_rst === 1'b0, "R8", "core_rst released at end", int'(core_rst), 0);
    finish_run();
  end
endmodule